// File: doc/BRIEF.md
# Kernel Memory Write Integrity Checker

This block watches a stream of store records taken from a processor trace port. Every record names the instruction that did the store, the address that was written and the value that was written. The block compares each record against four programmable tables and reports a verdict with a cause code for every record it accepts. The four tables are:

- protected kernel ranges that must never change, such as code and read-only data;
- watched data ranges;
- a list of acceptable data values;
- a list of code ranges that may legitimately write watched data.

A write into a protected range is reported first, before any other test is applied. A write into watched data must pass both tests: the value must be acceptable, and the writer must be allowed. A write that lands in neither kind of range is let through without further checks. A sticky alarm output keeps any violation visible until it is explicitly cleared. The tables are loaded through a simple single-cycle write port.

Top module: `kmw_guard`

## Requirements
- R1: A record whose data address hits a valid protected range gets cause 1 (protected write), whatever its value and instruction address.
- R2: A record whose data address hits no valid protected range and no valid watched range gets cause 0, and it does not set the alarm.
- R3: For a record into a watched range, a data value that matches no valid entry of the value list gives cause 2 (bad value).
- R4: For a record into a watched range, an acceptable value written by an instruction address outside every valid code range gives cause 3 (bad writer).
- R5: For a record into a watched range, an acceptable value written from inside a valid code range gives cause 0.
- R6: Every range is inclusive at both ends: an address equal to the base or to the limit is inside the range, and limit+1 is outside it.
- R7: After reset every table entry is invalid. An entry written with its enable bit at 0 never matches.
- R8: `out_valid` is high for exactly one cycle after each accepted record (`rec_valid` and `rec_ready` both high at a rising edge), and `out_cause` holds that record's cause in the same cycle. When no record was accepted, `out_valid` is 0 and `out_cause` is 0.
- R9: `alarm` is 0 after reset. It goes high in the same cycle as any nonzero cause and stays high until `clr` is pulsed. If a new violation is accepted in the same cycle as the clear, the alarm stays set.
- R10: A table write takes one cycle, and `cfg_sel` picks the table: 0 for protected ranges, 1 for watched ranges, 2 for the value list, 3 for code ranges. For the value list the value is taken from `cfg_lo`. While `cfg_we` is high, `rec_ready` is 0. At all other times `rec_ready` is 1.
- R11: When both the value and the writer fail for a watched write, cause 2 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | A store record is presented |
| rec_ready | output | 1 | Record can be taken this cycle |
| rec_pc | input | XLEN | Address of the storing instruction |
| rec_addr | input | XLEN | Data address written |
| rec_data | input | XLEN | Value written |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select (see R10) |
| cfg_idx | input | $clog2(ENTRIES) | Entry index |
| cfg_lo | input | XLEN | Range base, or the value for the value list |
| cfg_hi | input | XLEN | Range limit (ignored for the value list) |
| cfg_en | input | 1 | Entry enable bit |
| clr | input | 1 | Pulse to clear the sticky alarm |
| out_valid | output | 1 | Verdict for the record accepted on the previous edge |
| out_cause | output | 2 | 0 clean, 1 protected write, 2 bad value, 3 bad writer |
| alarm | output | 1 | Sticky violation flag |

## Verification
Two situations are the hardest to reach from the ports. The first is a watched write where the value and the writer are both wrong at once, because only the priority between the two failures decides the cause. The second is an entry that was valid and is later switched off. The stimulus loads overlapping tables so that a single record can fail several tests at the same time, and then it rewrites an entry with its enable bit cleared and replays a value that matched before. Boundary addresses at the base, at the limit and at limit+1 confirm that the ranges include both ends.

// File: rtl/kmw_pkg.sv
package kmw_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_IMMUT  = 2'd1,
        CAUSE_BADVAL = 2'd2,
        CAUSE_BADWR  = 2'd3
    } cause_t;

    typedef enum logic [1:0] {
        SEL_IMMUT = 2'd0,
        SEL_WATCH = 2'd1,
        SEL_VALUE = 2'd2,
        SEL_CODE  = 2'd3
    } tbl_sel_t;
endpackage

// File: rtl/kmw_range_tbl.sv
module kmw_range_tbl #(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_lo,
    input  logic [XLEN-1:0] wr_hi,
    input  logic            wr_valid,
    input  logic [XLEN-1:0] probe,
    output logic            hit
);
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] lo;
        logic [XLEN-1:0] hi;
    } range_t;

    range_t [ENTRIES-1:0] tbl_d, tbl_q;
    logic   [ENTRIES-1:0] match;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx].valid = wr_valid;
            tbl_d[wr_idx].lo    = wr_lo;
            tbl_d[wr_idx].hi    = wr_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl_q[g].valid && (probe >= tbl_q[g].lo) && (probe <= tbl_q[g].hi);
    end

    assign hit = |match;

    // R10: a table write is visible on the next cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)].valid == $past(wr_valid))
                  && (tbl_q[$past(wr_idx)].lo == $past(wr_lo)));
endmodule

// File: rtl/kmw_value_tbl.sv
module kmw_value_tbl #(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_val,
    input  logic            wr_valid,
    input  logic [XLEN-1:0] probe,
    output logic            hit
);
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] val;
    } val_t;

    val_t [ENTRIES-1:0] tbl_d, tbl_q;
    logic [ENTRIES-1:0] match;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx].valid = wr_valid;
            tbl_d[wr_idx].val   = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl_q[g].valid && (probe == tbl_q[g].val);
    end

    assign hit = |match;

    // R7: a disabled entry written this cycle is invalid next cycle
    p_disable_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !tbl_q[$past(wr_idx)].valid);
endmodule

// File: rtl/kmw_guard.sv
module kmw_guard #(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec_valid,
    output logic            rec_ready,
    input  logic [XLEN-1:0] rec_pc,
    input  logic [XLEN-1:0] rec_addr,
    input  logic [XLEN-1:0] rec_data,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [XLEN-1:0] cfg_lo,
    input  logic [XLEN-1:0] cfg_hi,
    input  logic            cfg_en,
    input  logic            clr,
    output logic            out_valid,
    output logic [1:0]      out_cause,
    output logic            alarm
);
    import kmw_pkg::*;

    typedef struct packed {
        logic   vld;
        cause_t cause;
        logic   alarm;
    } state_t;

    state_t state_d, state_q;
    logic   imm_hit, watch_hit, val_hit, code_hit;
    logic   accept;
    cause_t verdict;

    assign rec_ready = !cfg_we;
    assign accept    = rec_valid && rec_ready;

    kmw_range_tbl #(.ENTRIES(ENTRIES), .XLEN(XLEN)) u_immut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && (cfg_sel == SEL_IMMUT)), .wr_idx(cfg_idx),
        .wr_lo(cfg_lo), .wr_hi(cfg_hi), .wr_valid(cfg_en),
        .probe(rec_addr), .hit(imm_hit));

    kmw_range_tbl #(.ENTRIES(ENTRIES), .XLEN(XLEN)) u_watch (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && (cfg_sel == SEL_WATCH)), .wr_idx(cfg_idx),
        .wr_lo(cfg_lo), .wr_hi(cfg_hi), .wr_valid(cfg_en),
        .probe(rec_addr), .hit(watch_hit));

    kmw_value_tbl #(.ENTRIES(ENTRIES), .XLEN(XLEN)) u_value (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && (cfg_sel == SEL_VALUE)), .wr_idx(cfg_idx),
        .wr_val(cfg_lo), .wr_valid(cfg_en),
        .probe(rec_data), .hit(val_hit));

    kmw_range_tbl #(.ENTRIES(ENTRIES), .XLEN(XLEN)) u_code (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && (cfg_sel == SEL_CODE)), .wr_idx(cfg_idx),
        .wr_lo(cfg_lo), .wr_hi(cfg_hi), .wr_valid(cfg_en),
        .probe(rec_pc), .hit(code_hit));

    always_comb begin
        if (imm_hit)         verdict = CAUSE_IMMUT;
        else if (!watch_hit) verdict = CAUSE_NONE;
        else if (!val_hit)   verdict = CAUSE_BADVAL;
        else if (!code_hit)  verdict = CAUSE_BADWR;
        else                 verdict = CAUSE_NONE;
    end

    always_comb begin
        state_d       = state_q;
        state_d.vld   = accept;
        state_d.cause = accept ? verdict : CAUSE_NONE;
        state_d.alarm = (state_q.alarm && !clr) || (accept && (verdict != CAUSE_NONE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{vld: 1'b0, cause: CAUSE_NONE, alarm: 1'b0};
        else        state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign out_cause = state_q.cause;
    assign alarm     = state_q.alarm;

    // R1: protected hit wins over everything
    p_immut_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && imm_hit) |=> (out_cause == 2'd1));
    // R2: unwatched, unprotected records are clean
    p_unwatched_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !imm_hit && !watch_hit) |=> (out_cause == 2'd0));
    // R11: a bad value outranks a bad writer
    p_value_over_writer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !imm_hit && watch_hit && !val_hit) |=> (out_cause == 2'd2));
    // R8: one verdict per accepted record
    p_verdict_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!out_valid && out_cause == 2'd0));
    // R9: alarm holds without a clear, and drops after a clear with no record
    p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clr) |=> alarm);
    p_alarm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !accept) |=> !alarm);
    p_cause_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cause != 2'd0) |-> alarm);
    // R10: table writes block records
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !out_valid);
endmodule

// File: tb/kmw_guard_tb.sv
module kmw_guard_tb;
    localparam int XLEN = 32;
    localparam int IW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rec_valid = 1'b0;
    logic            rec_ready;
    logic [XLEN-1:0] rec_pc = '0, rec_addr = '0, rec_data = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_sel = '0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [XLEN-1:0] cfg_lo = '0, cfg_hi = '0;
    logic            cfg_en = 1'b0;
    logic            clr = 1'b0;
    logic            out_valid;
    logic [1:0]      out_cause;
    logic            alarm;

    int n_tests = 0;
    int n_fail  = 0;

    kmw_guard #(.ENTRIES(8), .XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_pc(rec_pc), .rec_addr(rec_addr), .rec_data(rec_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_en(cfg_en),
        .clr(clr), .out_valid(out_valid), .out_cause(out_cause), .alarm(alarm));

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input int idx,
                             input logic [31:0] lo, input logic [31:0] hi, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IW'(idx);
        cfg_lo = lo; cfg_hi = hi; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one record, then sample its verdict one edge later
    task automatic send(input logic [31:0] pc, input logic [31:0] addr, input logic [31:0] data,
                        input logic [1:0] exp_cause, input string req);
        @(negedge clk);
        rec_valid = 1'b1; rec_pc = pc; rec_addr = addr; rec_data = data;
        @(negedge clk);
        rec_valid = 1'b0;
        check({req, " out_valid"}, 32'(out_valid), 32'd1);
        check({req, " cause"}, 32'(out_cause), 32'(exp_cause));
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 alarm at reset", 32'(alarm), 32'd0);
        check("R8 out_valid at reset", 32'(out_valid), 32'd0);
        check("R10 ready when idle", 32'(rec_ready), 32'd1);
    endtask

    task automatic t_empty_tables();
        send(32'h3000, 32'h1000, 32'h1234, 2'd0, "R7 empty tables no match");
        check("R2 no alarm", 32'(alarm), 32'd0);
    endtask

    task automatic t_load();
        cfg_write(2'd0, 0, 32'h1000, 32'h1FFF, 1'b1);
        cfg_write(2'd1, 3, 32'h8000, 32'h80FF, 1'b1);
        cfg_write(2'd2, 0, 32'hAAAA, 32'h0, 1'b1);
        cfg_write(2'd2, 7, 32'h5555, 32'h0, 1'b1);
        cfg_write(2'd3, 1, 32'h2000, 32'h20FF, 1'b1);
    endtask

    task automatic t_unwatched();
        send(32'h9999, 32'h4000, 32'hDEAD, 2'd0, "R2 unwatched");
        send(32'h2000, 32'h8100, 32'hDEAD, 2'd0, "R6 watched limit+1 outside");
        check("R2 alarm stays low", 32'(alarm), 32'd0);
    endtask

    task automatic t_immut();
        send(32'h2000, 32'h1000, 32'hAAAA, 2'd1, "R1 protected base");
        check("R9 alarm set", 32'(alarm), 32'd1);
        send(32'h2000, 32'h1FFF, 32'hAAAA, 2'd1, "R6 protected limit");
        pulse_clr();
        check("R9 alarm cleared", 32'(alarm), 32'd0);
    endtask

    task automatic t_watched();
        send(32'h2000, 32'h8000, 32'h1234, 2'd2, "R3 bad value");
        pulse_clr();
        send(32'h3000, 32'h8010, 32'h1234, 2'd2, "R11 both fail");
        pulse_clr();
        send(32'h2100, 32'h8020, 32'hAAAA, 2'd3, "R4 bad writer limit+1");
        check("R9 alarm on bad writer", 32'(alarm), 32'd1);
        send(32'h20FF, 32'h80FF, 32'h5555, 2'd0, "R5 clean write at limits");
        check("R9 clean record keeps alarm", 32'(alarm), 32'd1);
        pulse_clr();
        send(32'h2000, 32'h8000, 32'hAAAA, 2'd0, "R5 clean write at bases");
        check("R5 no alarm", 32'(alarm), 32'd0);
    endtask

    task automatic t_disable();
        cfg_write(2'd2, 7, 32'h5555, 32'h0, 1'b0);
        send(32'h2000, 32'h8000, 32'h5555, 2'd2, "R7 disabled value entry");
        pulse_clr();
    endtask

    task automatic t_clear_race();
        send(32'h2000, 32'h1004, 32'h0, 2'd1, "R1 protected any value");
        @(negedge clk);
        clr = 1'b1; rec_valid = 1'b1; rec_pc = 32'h2000; rec_addr = 32'h1008; rec_data = 32'h0;
        @(negedge clk);
        clr = 1'b0; rec_valid = 1'b0;
        check("R9 violation beats clear", 32'(alarm), 32'd1);
        pulse_clr();
    endtask

    task automatic t_stall();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_idx = 3'd5; cfg_lo = 32'h0; cfg_hi = 32'h0; cfg_en = 1'b0;
        rec_valid = 1'b1; rec_addr = 32'h1000;
        #1;
        check("R10 ready low during cfg", 32'(rec_ready), 32'd0);
        @(negedge clk);
        cfg_we = 1'b0; rec_valid = 1'b0;
        check("R8 stalled record gives no verdict", 32'(out_valid), 32'd0);
        check("R10 stalled record no alarm", 32'(alarm), 32'd0);
        @(negedge clk);
        check("R8 idle out_valid low", 32'(out_valid), 32'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_empty_tables();
                t_load();
                t_unwatched();
                t_immut();
                t_watched();
                t_disable();
                t_clear_race();
                t_stall();
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule